// File: doc/BRIEF.md
# Line-Frequency Real-Time Clock with CPU Option Port

This block sits on a processor's programmed I/O bus and answers one device address with two unrelated jobs. The first is a real-time clock. A divider turns the system clock into line-frequency ticks, either 60 or 50 per second, and each tick advances a tick counter. When the counter rolls over to zero, a clock-ready flag is raised. That flag, gated by its bit in the interrupt enable mask, forms the clock interrupt request.

The second job is a CPU option port. A bus output command can load the whole interrupt enable mask. Another function code loads the CPU key bits: carry, double precision, extended addressing and shift count. Clearing extended addressing is deferred. It takes effect only on the next instruction-boundary pulse, so the instruction that turned it off still finishes in extended mode.

Each bus command is a single-cycle `io_valid` strobe. It carries an operation (control pulse, skip test, output transfer) and a function code. The skip answer and the illegal-function flag appear as registered one-cycle pulses in the cycle after the strobe.

Top module: `rtc_optport`

## Requirements
- R1: After reset, clock ready, the whole interrupt mask, the running flag, the tick counter, carry, double precision, extended mode and shift count are all zero.
- R2: Control pulse (io_op=0) with function 0 starts a stopped clock and restarts the tick divider from zero, so the n-th tick lands exactly n*LIM_60 (or n*LIM_50) cycles after the command edge; on a running clock it does not disturb the divider phase.
- R3: Each tick adds one to the tick counter modulo 2^CNT_W. The tick that produces zero sets clock ready. A wrap and a ready-clearing command in the same cycle leave ready set.
- R4: With rate_50=0 the tick period is LIM_60 system cycles; with rate_50=1 it is LIM_50 cycles.
- R5: Control pulse function 2 stops the clock and the counter then holds its value; control functions 0 and 2 both clear clock ready.
- R6: Skip test (io_op=1) function 0 skips when ready AND int_mask[CLK_BIT] is false; function 6'o02 skips when parity_err is low; function 6'o12 skips when parity_err is high.
- R7: Output transfer (io_op=2) function 0 loads int_mask from io_data; clk_irq equals clk_ready AND int_mask[CLK_BIT].
- R8: Output transfer function 6'o10 loads carry from io_data[15] and shift count from io_data[4:0], and loads double precision from io_data[14] only when dp_present is high.
- R9: On that key load with ext_present high, io_data[13]=1 sets extended mode at once and cancels any pending clear; io_data[13]=0 arms a pending clear that drops extended mode on the next insn_boundary pulse. With ext_present low, extended mode and the pending clear are left untouched.
- R10: Any other operation/function pair, including io_op=3, raises bad_fn, gives no skip and changes no state.
- R11: skip and bad_fn are pulses one cycle long, in the cycle right after the io_valid strobe, and are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Bus command strobe, one cycle |
| io_op | input | 2 | Operation: 0 control pulse, 1 skip test, 2 output transfer, 3 input transfer |
| io_fn | input | 6 | Function code |
| io_data | input | DATA_W | Output transfer data |
| rate_50 | input | 1 | 1 selects 50 ticks/s, 0 selects 60 ticks/s |
| parity_err | input | 1 | Memory parity error status |
| dp_present | input | 1 | Double-precision option is fitted |
| ext_present | input | 1 | Extended-addressing option is fitted |
| insn_boundary | input | 1 | Instruction boundary pulse |
| skip | output | 1 | Skip answer for the previous command |
| bad_fn | output | 1 | Previous command was illegal |
| int_mask | output | DATA_W | Interrupt enable mask |
| clk_running | output | 1 | Clock is running |
| clk_ready | output | 1 | Clock ready flag |
| clk_irq | output | 1 | Clock interrupt request |
| tick_count | output | CNT_W | Tick counter |
| carry_key | output | 1 | Carry key |
| dp_key | output | 1 | Double-precision key |
| ext_mode | output | 1 | Extended addressing mode |
| shift_cnt | output | 5 | Shift count key |

## Verification
The bench builds the block with CNT_W=8, LIM_60=4 and LIM_50=6. With these values a full counter rollover takes about a thousand cycles, so ready-on-wrap and the skip and interrupt behaviour that follows it can be checked at exact cycles. The two unequal small divider limits make the rate select, the restart on start, and the divider phase kept by a second start all show up as one-cycle differences in when the counter steps.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    IO_CTRL = 2'd0,
    IO_SKIP = 2'd1,
    IO_OUT  = 2'd2,
    IO_IN   = 2'd3
  } io_op_e;

  localparam logic [5:0] FN_CLK_RUN    = 6'o00;
  localparam logic [5:0] FN_CLK_HALT   = 6'o02;
  localparam logic [5:0] FN_Q_NOREQ    = 6'o00;
  localparam logic [5:0] FN_Q_PAR_OK   = 6'o02;
  localparam logic [5:0] FN_Q_PAR_BAD  = 6'o12;
  localparam logic [5:0] FN_LD_MASK    = 6'o00;
  localparam logic [5:0] FN_LD_KEYS    = 6'o10;

  typedef struct packed {
    logic run;
    logic halt;
    logic q_noreq;
    logic q_par_ok;
    logic q_par_bad;
    logic ld_mask;
    logic ld_keys;
    logic illegal;
  } io_cmd_t;

endpackage

// File: rtl/rtc_io_decode.sv
module rtc_io_decode
  import rtc_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] op,
  input  logic [5:0] fn,
  output io_cmd_t    cmd
);

  always_comb begin
    cmd = '0;
    if (valid) begin
      case (io_op_e'(op))
        IO_CTRL: begin
          if (fn == FN_CLK_RUN)       cmd.run  = 1'b1;
          else if (fn == FN_CLK_HALT) cmd.halt = 1'b1;
          else                        cmd.illegal = 1'b1;
        end
        IO_SKIP: begin
          if (fn == FN_Q_NOREQ)        cmd.q_noreq   = 1'b1;
          else if (fn == FN_Q_PAR_OK)  cmd.q_par_ok  = 1'b1;
          else if (fn == FN_Q_PAR_BAD) cmd.q_par_bad = 1'b1;
          else                         cmd.illegal   = 1'b1;
        end
        IO_OUT: begin
          if (fn == FN_LD_MASK)      cmd.ld_mask = 1'b1;
          else if (fn == FN_LD_KEYS) cmd.ld_keys = 1'b1;
          else                       cmd.illegal = 1'b1;
        end
        default: cmd.illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned LIM_A = 833333,
  parameter int unsigned LIM_B = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic sel_b,
  output logic tick
);

  localparam int unsigned LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int DW = $clog2(LIM_MAX + 1);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] last;

  assign last = sel_b ? DW'(LIM_B - 1) : DW'(LIM_A - 1);
  // >= keeps the period bounded if the rate changes mid-period
  assign tick = run && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_tick_count.sv
module rtc_tick_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  logic [CNT_W-1:0] count_q;

  assign count = count_q;
  assign wrap  = tick && (count_q == '1);

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= count_q + 1'b1;
  end

endmodule

// File: rtl/rtc_cpu_keys.sv
module rtc_cpu_keys #(
  parameter int SC_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            d_carry,
  input  logic            d_dp,
  input  logic            d_ext,
  input  logic [SC_W-1:0] d_shift,
  input  logic            dp_present,
  input  logic            ext_present,
  input  logic            boundary,
  output logic            carry,
  output logic            dp,
  output logic            ext,
  output logic [SC_W-1:0] shift
);

  logic ext_clr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      carry        <= 1'b0;
      dp           <= 1'b0;
      ext          <= 1'b0;
      ext_clr_pend <= 1'b0;
      shift        <= '0;
    end else if (load) begin
      carry <= d_carry;
      shift <= d_shift;
      if (dp_present) dp <= d_dp;
      if (ext_present) begin
        if (d_ext) begin
          ext          <= 1'b1;
          ext_clr_pend <= 1'b0;
        end else begin
          ext_clr_pend <= 1'b1;
        end
      end
    end else if (boundary && ext_clr_pend) begin
      ext          <= 1'b0;
      ext_clr_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_optport.sv
module rtc_optport
  import rtc_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter int          DATA_W  = 16,
  parameter int          CLK_BIT = 3,
  parameter int unsigned LIM_60  = 833333,
  parameter int unsigned LIM_50  = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_valid,
  input  logic [1:0]        io_op,
  input  logic [5:0]        io_fn,
  input  logic [DATA_W-1:0] io_data,
  input  logic              rate_50,
  input  logic              parity_err,
  input  logic              dp_present,
  input  logic              ext_present,
  input  logic              insn_boundary,
  output logic              skip,
  output logic              bad_fn,
  output logic [DATA_W-1:0] int_mask,
  output logic              clk_running,
  output logic              clk_ready,
  output logic              clk_irq,
  output logic [CNT_W-1:0]  tick_count,
  output logic              carry_key,
  output logic              dp_key,
  output logic              ext_mode,
  output logic [4:0]        shift_cnt
);

  localparam int SC_W = 5;

  io_cmd_t cmd;
  logic    run_q, ready_q, skip_q, bad_q;
  logic [DATA_W-1:0] mask_q;
  logic    tick, wrap, restart, irq_req;

  rtc_io_decode u_dec (
    .valid (io_valid),
    .op    (io_op),
    .fn    (io_fn),
    .cmd   (cmd)
  );

  assign restart = cmd.run && !run_q;

  rtc_tick_div #(.LIM_A(LIM_60), .LIM_B(LIM_50)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .restart (restart),
    .sel_b   (rate_50),
    .tick    (tick)
  );

  rtc_tick_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .count (tick_count),
    .wrap  (wrap)
  );

  rtc_cpu_keys #(.SC_W(SC_W)) u_keys (
    .clk         (clk),
    .rst         (rst),
    .load        (cmd.ld_keys),
    .d_carry     (io_data[15]),
    .d_dp        (io_data[14]),
    .d_ext       (io_data[13]),
    .d_shift     (io_data[SC_W-1:0]),
    .dp_present  (dp_present),
    .ext_present (ext_present),
    .boundary    (insn_boundary),
    .carry       (carry_key),
    .dp          (dp_key),
    .ext         (ext_mode),
    .shift       (shift_cnt)
  );

  assign irq_req = ready_q && mask_q[CLK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      ready_q <= 1'b0;
      mask_q  <= '0;
      skip_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      if (cmd.halt)     run_q <= 1'b0;
      else if (cmd.run) run_q <= 1'b1;

      // a wrap in the same cycle as a clearing command wins
      if (wrap)                      ready_q <= 1'b1;
      else if (cmd.run || cmd.halt)  ready_q <= 1'b0;

      if (cmd.ld_mask) mask_q <= io_data;

      skip_q <= (cmd.q_noreq   && !irq_req)
             || (cmd.q_par_ok  && !parity_err)
             || (cmd.q_par_bad &&  parity_err);
      bad_q  <= cmd.illegal;
    end
  end

  assign skip        = skip_q;
  assign bad_fn      = bad_q;
  assign int_mask    = mask_q;
  assign clk_running = run_q;
  assign clk_ready   = ready_q;
  assign clk_irq     = irq_req;

endmodule

// File: rtl/rtc_optport_chk.sv
module rtc_optport_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             io_valid,
  input logic [1:0]       io_op,
  input logic [5:0]       io_fn,
  input logic             io_d13,
  input logic             ext_present,
  input logic             skip,
  input logic             bad_fn,
  input logic             clk_running,
  input logic             clk_ready,
  input logic [CNT_W-1:0] tick_count,
  input logic             ext_mode
);

  a_r10_bad_no_skip: assert property (@(posedge clk) disable iff (rst)
    bad_fn |-> !skip);

  a_r11_pulse_after_cmd: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(io_valid)) |-> (!skip && !bad_fn));

  a_r5_halt_stops: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_op == 2'd0 && io_fn == 6'o02) |=> !clk_running);

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    !clk_running |=> $stable(tick_count));

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tick_count != $past(tick_count))
      |-> tick_count == CNT_W'($past(tick_count) + 1'b1));

  a_r3_ready_on_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_ready) |-> tick_count == '0);

  a_r9_ext_immediate: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_op == 2'd2 && io_fn == 6'o10 && io_d13 && ext_present)
      |=> ext_mode);

endmodule

bind rtc_optport rtc_optport_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .io_valid    (io_valid),
  .io_op       (io_op),
  .io_fn       (io_fn),
  .io_d13      (io_data[13]),
  .ext_present (ext_present),
  .skip        (skip),
  .bad_fn      (bad_fn),
  .clk_running (clk_running),
  .clk_ready   (clk_ready),
  .tick_count  (tick_count),
  .ext_mode    (ext_mode)
);

// File: tb/rtc_optport_tb_top.sv
`timescale 1ns/1ps
module rtc_optport_tb_top;

  localparam int CNT_W = 8;
  localparam int L60   = 4;
  localparam int L50   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_valid = 1'b0;
  logic [1:0] io_op = '0;
  logic [5:0] io_fn = '0;
  logic [15:0] io_data = '0;
  logic rate_50 = 1'b0, parity_err = 1'b0, dp_present = 1'b0;
  logic ext_present = 1'b0, insn_boundary = 1'b0;
  logic skip, bad_fn, clk_running, clk_ready, clk_irq;
  logic carry_key, dp_key, ext_mode;
  logic [15:0] int_mask;
  logic [CNT_W-1:0] tick_count;
  logic [4:0] shift_cnt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rtc_optport #(.CNT_W(CNT_W), .DATA_W(16), .CLK_BIT(3),
                .LIM_60(L60), .LIM_50(L50)) dut_i (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_op(io_op), .io_fn(io_fn),
    .io_data(io_data), .rate_50(rate_50), .parity_err(parity_err),
    .dp_present(dp_present), .ext_present(ext_present),
    .insn_boundary(insn_boundary), .skip(skip), .bad_fn(bad_fn),
    .int_mask(int_mask), .clk_running(clk_running), .clk_ready(clk_ready),
    .clk_irq(clk_irq), .tick_count(tick_count), .carry_key(carry_key),
    .dp_key(dp_key), .ext_mode(ext_mode), .shift_cnt(shift_cnt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic io(input logic [1:0] op, input logic [5:0] fn, input logic [15:0] d);
    io_valid = 1'b1; io_op = op; io_fn = fn; io_data = d;
    @(negedge clk);
    io_valid = 1'b0; io_op = '0; io_fn = '0; io_data = '0;
  endtask

  task automatic boundary_pulse();
    insn_boundary = 1'b1;
    @(negedge clk);
    insn_boundary = 1'b0;
  endtask

  // {op, fn, parity_err, expected skip, expected bad_fn}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {2'd1, 6'o00, 1'b0, 1'b1, 1'b0},
    {2'd1, 6'o02, 1'b0, 1'b1, 1'b0},
    {2'd1, 6'o02, 1'b1, 1'b0, 1'b0},
    {2'd1, 6'o12, 1'b1, 1'b1, 1'b0},
    {2'd1, 6'o12, 1'b0, 1'b0, 1'b0},
    {2'd1, 6'o01, 1'b0, 1'b0, 1'b1},
    {2'd1, 6'o04, 1'b1, 1'b0, 1'b1},
    {2'd0, 6'o01, 1'b0, 1'b0, 1'b1},
    {2'd0, 6'o04, 1'b0, 1'b0, 1'b1},
    {2'd2, 6'o02, 1'b0, 1'b0, 1'b1},
    {2'd2, 6'o11, 1'b0, 1'b0, 1'b1},
    {2'd3, 6'o00, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ready", clk_ready, 0);
    check("R1 mask", int_mask, 0);
    check("R1 running", clk_running, 0);
    check("R1 count", tick_count, 0);
    check("R1 keys", {carry_key, dp_key, ext_mode, shift_cnt}, 0);

    // R6 R10 R11 vector walk
    for (int i = 0; i < NV; i++) begin
      parity_err = VEC[i][2];
      io(VEC[i][10:9], VEC[i][8:3], 16'h0);
      check($sformatf("R6/R10 vec%0d skip", i), skip, VEC[i][1]);
      check($sformatf("R10 vec%0d bad", i), bad_fn, VEC[i][0]);
      @(negedge clk);
      check($sformatf("R11 vec%0d pulse", i), {skip, bad_fn}, 0);
    end
    parity_err = 1'b0;
    check("R10 no state change", {clk_running, clk_ready, int_mask}, 0);

    // R7 mask load, R10 illegal output ignored
    io(2'd2, 6'o00, 16'h0008);
    check("R7 mask load", int_mask, 16'h0008);
    io(2'd2, 6'o04, 16'hFFFF);
    check("R10 illegal out ignored", int_mask, 16'h0008);

    // R8 R9 keys
    dp_present = 1'b1; ext_present = 1'b1;
    io(2'd2, 6'o10, 16'hE015);
    check("R8 carry", carry_key, 1);
    check("R8 dp", dp_key, 1);
    check("R8 shift", shift_cnt, 5'h15);
    check("R9 ext set", ext_mode, 1);
    dp_present = 1'b0;
    io(2'd2, 6'o10, 16'h0003);
    check("R8 carry clear", carry_key, 0);
    check("R8 dp absent kept", dp_key, 1);
    check("R8 shift 3", shift_cnt, 3);
    check("R9 clear deferred", ext_mode, 1);
    boundary_pulse();
    check("R9 clear at boundary", ext_mode, 0);
    io(2'd2, 6'o10, 16'h0000);
    io(2'd2, 6'o10, 16'h2000);
    check("R9 set again", ext_mode, 1);
    boundary_pulse();
    check("R9 pending cancelled", ext_mode, 1);
    ext_present = 1'b0;
    io(2'd2, 6'o10, 16'h0000);
    boundary_pulse();
    check("R9 ext absent no arm", ext_mode, 1);

    // R2 R3 R4 clock at 60 rate
    io(2'd0, 6'o00, 16'h0);
    check("R2 running", clk_running, 1);
    repeat (3 * L60 - 1) @(negedge clk);
    check("R2 before third tick", tick_count, 2);
    @(negedge clk);
    check("R3 third tick", tick_count, 3);
    io(2'd0, 6'o00, 16'h0);
    repeat (2) @(negedge clk);
    check("R2 restart while running", tick_count, 3);
    @(negedge clk);
    check("R2 phase kept", tick_count, 4);
    io(2'd0, 6'o02, 16'h0);
    check("R5 stopped", clk_running, 0);
    repeat (20) @(negedge clk);
    check("R5 count held", tick_count, 4);

    // R4 50 rate
    rate_50 = 1'b1;
    io(2'd0, 6'o00, 16'h0);
    repeat (2 * L50 - 1) @(negedge clk);
    check("R4 50 rate one tick", tick_count, 5);
    @(negedge clk);
    check("R4 50 rate two ticks", tick_count, 6);

    // R1 reset while running
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset again", {clk_running, clk_ready, ext_mode, int_mask}, 0);
    check("R1 count again", tick_count, 0);

    // R3 wrap, R6 R7 irq and skip
    rate_50 = 1'b0;
    io(2'd2, 6'o00, 16'h0008);
    io(2'd0, 6'o00, 16'h0);
    repeat (256 * L60 - 1) @(negedge clk);
    check("R3 count 255", tick_count, 255);
    check("R3 not ready yet", clk_ready, 0);
    @(negedge clk);
    check("R3 wrapped", tick_count, 0);
    check("R3 ready on wrap", clk_ready, 1);
    check("R7 irq", clk_irq, 1);
    io(2'd1, 6'o00, 16'h0);
    check("R6 no skip with request", skip, 0);
    io(2'd2, 6'o00, 16'h0000);
    check("R7 irq masked", clk_irq, 0);
    io(2'd1, 6'o00, 16'h0);
    check("R6 skip when disabled", skip, 1);
    io(2'd0, 6'o00, 16'h0);
    check("R5 start clears ready", clk_ready, 0);
    check("R2 still running", clk_running, 1);
    for (int k = 0; k < 2000 && !clk_ready; k++) @(negedge clk);
    check("R3 second wrap", clk_ready, 1);
    io(2'd0, 6'o02, 16'h0);
    check("R5 stop clears ready", {clk_running, clk_ready}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule